// File: doc/BRIEF.md
# Clock-Sampled Single-Slope ADC Capture

This block is the digital back end of a multi-channel single-slope converter. It drives a complementary pair of output pins with a 50% duty square wave, and an external RC network turns that wave into a ramp reference. The ramp rises while the positive pin is high and falls while it is low. Every channel has a comparator that checks its input against the ramp. The comparator output reaches the block asynchronously.

The comparator output is treated as data, never as a clock. A flip-flop on the system clock samples it, and two more flops synchronise it. A qualifying transition in the synchronised stream selects the value of a plain binary coarse counter. The counter restarts at each square-wave toggle. The captured value is corrected for the three-cycle sampling pipeline, so a crossing during cycle k of a half-period reports k. When the dual-edge option is set, a second sampler on the falling clock edge adds one bit below the count.

At the end of each half-period every channel produces one result: a code, a direction tag and an overrange flag. The results of one half-period form a batch. The batch leaves through a valid/ready stream in ascending channel order. A result is transferred on a cycle with both valid and ready high. While ready is low, valid and all result fields are held. A batch arrives at the end of a half-period. If the previous batch has not fully drained at that point, the new batch is discarded as a whole and the older batch keeps draining.

Top module: `ramp_adc_capture`

## Requirements
- R1: `ramp_p_o` and `ramp_n_o` are always complementary. After reset `ramp_p_o` is 0. Both pins toggle together once every 2^NBITS clock cycles.
- R2: The cycle on which the pins toggle is cycle 0 of a half-period. A crossing during cycle k reports the count k. With DUAL=1 the code is {k, lsb}.
- R3: A half-period with `ramp_p_o`=1 is a rising ramp. It captures a 0-to-1 change of the sampled comparator, and its results carry `res_dir_o`=1. A half-period with `ramp_p_o`=0 captures a 1-to-0 change, and its results carry `res_dir_o`=0.
- R4: Only the first qualifying transition in a half-period is captured. Later transitions in the same half-period, in either direction, do not change the reported code.
- R5: If a half-period has no qualifying transition, the channel reports an all-ones code with `res_over_o`=1. A crossing in the last cycle, second half, also reports all ones, but with `res_over_o`=0.
- R6: With DUAL=1, the code LSB is 0 when the crossing falls before the falling clock edge inside cycle k. It is 1 when the crossing falls after that edge.
- R7: Each half-period yields exactly one result per channel. The results leave with `res_chan_o` ascending from 0.
- R8: While `res_valid_o`=1 and `res_ready_i`=0, valid stays high and channel, direction, overrange and code stay unchanged.
- R9: A batch that arrives while results of the previous batch are still undelivered is dropped entirely.
- R10: During and right after reset `res_valid_o` is 0. The first reported batch belongs to the falling half-period that begins at reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_i | input | NCH | Asynchronous comparator outputs, one per channel |
| ramp_p_o | output | 1 | Square wave, positive pin (high = rising ramp) |
| ramp_n_o | output | 1 | Square wave, complementary pin |
| res_valid_o | output | 1 | A result is offered |
| res_ready_i | input | 1 | Consumer accepts the offered result |
| res_chan_o | output | CW | Channel index of the result |
| res_dir_o | output | 1 | 1 = rising-ramp result, 0 = falling-ramp result |
| res_over_o | output | 1 | No crossing in the half-period |
| res_code_o | output | W | Crossing time, NBITS + DUAL bits |

## Verification
The embedded properties check on every cycle:
- the pins stay complementary and change only at counter wrap;
- the frame counter trails the drive counter by exactly the pipeline latency, and its ramp direction matches the pins;
- a captured code does not move once taken;
- offered results are held while stalled, and channels leave in ascending order;
- an overrange result carries the saturated code.

The timing alignment, the half-cycle bit, glitch rejection, the direction tag and the dropping of a batch under long back-pressure depend on where the comparator edges fall relative to the clock. Only the bench's timed scenarios can show these.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  // direction of the reference ramp during a half-period
  typedef enum logic {DIR_FALL = 1'b0, DIR_RISE = 1'b1} ramp_dir_e;
  // sampling flop plus two synchroniser flops
  localparam int SYNC_DEPTH  = 2;
  localparam int CAPTURE_LAT = SYNC_DEPTH + 1;
endpackage

// File: rtl/rac_timebase.sv
module rac_timebase
  import ramp_adc_pkg::*;
#(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ramp_p_o,
  output logic             ramp_n_o,
  output logic [NBITS-1:0] fcnt_o,
  output ramp_dir_e        fdir_o,
  output logic             fend_o
);
  localparam logic [NBITS-1:0] CMAX  = '1;
  localparam logic [NBITS-1:0] LAT_V = NBITS'(CAPTURE_LAT);

  logic [NBITS-1:0] hcnt_q, fcnt_q;
  logic             rp_q, rn_q, primed_q;
  ramp_dir_e        fph_q;

  // drive counter and registered pin pair
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      rp_q   <= 1'b0;
      rn_q   <= 1'b1;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
      if (hcnt_q == CMAX) begin
        rp_q <= ~rp_q;
        rn_q <= ~rn_q;
      end
    end
  end

  // frame counter: trails the drive counter by the capture latency
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q   <= '0 - LAT_V;
      fph_q    <= DIR_RISE;
      primed_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_q + 1'b1;
      if (fcnt_q == CMAX) begin
        fph_q    <= (fph_q == DIR_RISE) ? DIR_FALL : DIR_RISE;
        primed_q <= 1'b1;
      end
    end
  end

  assign ramp_p_o = rp_q;
  assign ramp_n_o = rn_q;
  assign fcnt_o   = fcnt_q;
  assign fdir_o   = fph_q;
  assign fend_o   = primed_q && (fcnt_q == CMAX);

  p_pins_compl_r1: assert property (@(posedge clk) disable iff (rst) rp_q != rn_q)
    else $error("R1 pins not complementary");
  p_half_len_r1: assert property (@(posedge clk) disable iff (rst)
    (hcnt_q != CMAX) |=> $stable(rp_q))
    else $error("R1 pin moved mid half-period");
  p_frame_lag_r2: assert property (@(posedge clk) disable iff (rst)
    fcnt_q == hcnt_q - LAT_V)
    else $error("R2 frame counter misaligned");
  p_frame_dir_r3: assert property (@(posedge clk) disable iff (rst)
    (hcnt_q >= LAT_V) |-> ((fph_q == DIR_RISE) == rp_q))
    else $error("R3 frame direction disagrees with pins");
endmodule

// File: rtl/rac_chan.sv
module rac_chan
  import ramp_adc_pkg::*;
#(
  parameter int NBITS = 7,
  parameter int DUAL  = 1,
  localparam int W    = NBITS + DUAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             comp_i,
  input  logic [NBITS-1:0] fcnt_i,
  input  ramp_dir_e        fdir_i,
  output logic [W-1:0]     fin_code_o,
  output logic             fin_over_o
);
  localparam logic [NBITS-1:0] CMAX = '1;

  // sh[0] sampling flop, sh[1..2] synchroniser, sh[3] previous value
  logic [SYNC_DEPTH+1:0] sh_q;
  logic [W-1:0]          code_now, code_q;
  logic                  hit_q, rise, fall, qual;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_DEPTH:0], comp_i};
  end

  generate
    if (DUAL != 0) begin : g_dual
      logic                  n0_q;
      logic [SYNC_DEPTH:0]   nsh_q;
      always_ff @(negedge clk) begin
        if (rst) n0_q <= 1'b0;
        else     n0_q <= comp_i;
      end
      always_ff @(posedge clk) begin
        if (rst) nsh_q <= '0;
        else     nsh_q <= {nsh_q[SYNC_DEPTH-1:0], n0_q};
      end
      // falling-edge sampler already held the new level -> early half
      assign code_now = {fcnt_i, nsh_q[SYNC_DEPTH] ^ sh_q[SYNC_DEPTH]};
    end else begin : g_single
      assign code_now = fcnt_i;
    end
  endgenerate

  assign rise = sh_q[SYNC_DEPTH] & ~sh_q[SYNC_DEPTH+1];
  assign fall = ~sh_q[SYNC_DEPTH] & sh_q[SYNC_DEPTH+1];
  assign qual = (fdir_i == DIR_RISE) ? rise : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else if (fcnt_i == CMAX) begin
      hit_q <= 1'b0;
    end else if (qual && !hit_q) begin
      hit_q  <= 1'b1;
      code_q <= code_now;
    end
  end

  always_comb begin
    if (hit_q) begin
      fin_code_o = code_q;
      fin_over_o = 1'b0;
    end else if (qual) begin
      fin_code_o = code_now;
      fin_over_o = 1'b0;
    end else begin
      fin_code_o = '1;
      fin_over_o = 1'b1;
    end
  end

  p_first_only_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_q && fcnt_i != CMAX) |=> (hit_q && $stable(code_q)))
    else $error("R4 captured code changed after first crossing");
endmodule

// File: rtl/rac_drain.sv
module rac_drain
  import ramp_adc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  ramp_dir_e        dir_i,
  input  logic [NCH*W-1:0] codes_i,
  input  logic [NCH-1:0]   overs_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [CW-1:0]    chan_o,
  output logic             dir_o,
  output logic             over_o,
  output logic [W-1:0]     code_o
);
  logic [NCH-1:0] pend_q, clr, remain;
  logic [W-1:0]   bcode_q [NCH];
  logic [NCH-1:0] bover_q;
  ramp_dir_e      bdir_q;
  logic [CW-1:0]  sel;
  logic           accept, take;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) sel = CW'(i);
  end

  assign accept = valid_o && ready_i;
  assign clr    = accept ? (NCH'(1) << sel) : '0;
  assign remain = pend_q & ~clr;
  assign take   = load_i && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      bover_q <= '0;
      bdir_q  <= DIR_FALL;
      for (int i = 0; i < NCH; i++) bcode_q[i] <= '0;
    end else if (take) begin
      pend_q  <= '1;
      bover_q <= overs_i;
      bdir_q  <= dir_i;
      for (int i = 0; i < NCH; i++) bcode_q[i] <= codes_i[i*W +: W];
    end else begin
      pend_q <= remain;
    end
  end

  assign valid_o = |pend_q;
  assign chan_o  = sel;
  assign dir_o   = bdir_q;
  assign over_o  = bover_q[sel];
  assign code_o  = bcode_q[sel];

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(chan_o) && $stable(code_o)
                               && $stable(over_o) && $stable(dir_o)))
    else $error("R8 offered result changed while stalled");
  p_order_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && remain != '0) |=> (chan_o > $past(chan_o)))
    else $error("R7 channel order broken");
  p_over_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && over_o) |-> (code_o == '1))
    else $error("R5 overrange without saturated code");
endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture
  import ramp_adc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NBITS = 7,
  parameter int DUAL  = 1,
  localparam int W    = NBITS + DUAL,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] comp_i,
  output logic           ramp_p_o,
  output logic           ramp_n_o,
  output logic           res_valid_o,
  input  logic           res_ready_i,
  output logic [CW-1:0]  res_chan_o,
  output logic           res_dir_o,
  output logic           res_over_o,
  output logic [W-1:0]   res_code_o
);
  logic [NBITS-1:0] fcnt;
  ramp_dir_e        fdir;
  logic             fend;
  logic [NCH*W-1:0] codes;
  logic [NCH-1:0]   overs;

  rac_timebase #(.NBITS(NBITS)) u_tb (
    .clk(clk), .rst(rst), .ramp_p_o(ramp_p_o), .ramp_n_o(ramp_n_o),
    .fcnt_o(fcnt), .fdir_o(fdir), .fend_o(fend)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      rac_chan #(.NBITS(NBITS), .DUAL(DUAL)) u_ch (
        .clk(clk), .rst(rst), .comp_i(comp_i[c]), .fcnt_i(fcnt), .fdir_i(fdir),
        .fin_code_o(codes[c*W +: W]), .fin_over_o(overs[c])
      );
    end
  endgenerate

  rac_drain #(.NCH(NCH), .W(W)) u_dr (
    .clk(clk), .rst(rst), .load_i(fend), .dir_i(fdir), .codes_i(codes),
    .overs_i(overs), .valid_o(res_valid_o), .ready_i(res_ready_i),
    .chan_o(res_chan_o), .dir_o(res_dir_o), .over_o(res_over_o),
    .code_o(res_code_o)
  );
endmodule

// File: tb/ramp_adc_capture_test.sv
module ramp_adc_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, NBITS = 4, DUAL = 1, W = 5;
  localparam int HALF = 16;

  logic clk = 1'b0, rst = 1'b1, ready = 1'b1;
  logic [1:0] comp = 2'b00;
  logic ramp_p, ramp_n, valid, dir, over;
  logic [0:0] chan;
  logic [4:0] code;

  int ntests = 0, nfail = 0;
  logic [7:0] got [0:255];
  logic [7:0] expv [0:63];
  int ngot = 0, nexp = 0;

  // vector: [12] glitch ch0, [11] none ch1, [10:6] code ch1, [5] none ch0, [4:0] code ch0
  localparam int NV = 9;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 5'd21, 1'b0, 5'd6 },
    {1'b1, 1'b0, 5'd31, 1'b0, 5'd0 },
    {1'b0, 1'b0, 5'd1 , 1'b0, 5'd31},
    {1'b0, 1'b0, 5'd14, 1'b1, 5'd0 },
    {1'b0, 1'b0, 5'd17, 1'b1, 5'd0 },
    {1'b0, 1'b0, 5'd4 , 1'b0, 5'd11},
    {1'b1, 1'b1, 5'd0 , 1'b0, 5'd2 },
    {1'b0, 1'b1, 5'd0 , 1'b0, 5'd24},
    {1'b0, 1'b0, 5'd18, 1'b0, 5'd13}
  };

  ramp_adc_capture #(.NCH(NCH), .NBITS(NBITS), .DUAL(DUAL)) uut (
    .clk(clk), .rst(rst), .comp_i(comp), .ramp_p_o(ramp_p), .ramp_n_o(ramp_n),
    .res_valid_o(valid), .res_ready_i(ready), .res_chan_o(chan),
    .res_dir_o(dir), .res_over_o(over), .res_code_o(code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (!rst && valid && ready && ngot < 256) begin
      got[ngot] = {chan, dir, over, code};
      ngot++;
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic wait_half(input logic d);
    logic prev;
    prev = ramp_p;
    forever begin
      @(posedge clk); #1;
      if (ramp_p == d && prev != d) break;
      prev = ramp_p;
    end
  endtask

  task automatic push_exp(input logic c, input logic d, input logic o, input logic [4:0] cd);
    expv[nexp] = {c, d, o, cd};
    nexp++;
  endtask

  task automatic drive_ch(input int c, input logic [4:0] cd, input bit none, input bit glitch);
    int k;
    if (none) return;
    k = int'(cd[4:1]);
    if (k > 0) repeat (k) @(posedge clk);
    if (cd[0]) #7; else #2;
    comp[c] = ~comp[c];
    if (glitch) begin
      repeat (3) @(posedge clk); #2; comp[c] = ~comp[c];
      repeat (2) @(posedge clk); #2; comp[c] = ~comp[c];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int start, cnt;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    chk(valid == 1'b0, "R10", "valid after reset", valid, 0);
    chk(ramp_p == 1'b0, "R1", "ramp_p after reset", ramp_p, 0);
    chk(ramp_n == 1'b1, "R1", "ramp_n after reset", ramp_n, 1);
    // R10: first batch is the falling half-period from reset, no crossing
    push_exp(1'b0, 1'b0, 1'b1, 5'd31);
    push_exp(1'b1, 1'b0, 1'b1, 5'd31);

    for (int v = 0; v < NV; v++) begin
      logic d;
      d = (v % 2 == 0);
      wait_half(d);
      push_exp(1'b0, d, VEC[v][5],  VEC[v][5]  ? 5'd31 : VEC[v][4:0]);
      push_exp(1'b1, d, VEC[v][11], VEC[v][11] ? 5'd31 : VEC[v][10:6]);
      fork
        drive_ch(0, VEC[v][4:0],  VEC[v][5],  VEC[v][12]);
        drive_ch(1, VEC[v][10:6], VEC[v][11], 1'b0);
      join
    end
    repeat (40) @(posedge clk);

    chk(ngot >= nexp, "R7", "result count", ngot, nexp);
    for (int i = 0; i < nexp; i++) begin
      string tag;
      tag = expv[i][5] ? "R5" : "R2";
      if (i >= 2 && expv[i][7] == 1'b0 && VEC[(i-2)/2][12]) tag = "R4";
      chk(got[i][4:0] == expv[i][4:0], tag, "code", got[i][4:0], expv[i][4:0]);
      chk(got[i][5] == expv[i][5], "R5", "overrange flag", got[i][5], expv[i][5]);
      chk(got[i][6] == expv[i][6], "R3", "direction", got[i][6], expv[i][6]);
      chk(got[i][7] == expv[i][7], "R7", "channel order", got[i][7], expv[i][7]);
      if (!expv[i][5])
        chk(got[i][0] == expv[i][0], "R6", "half-cycle bit", got[i][0], expv[i][0]);
    end

    // back-pressure: hold one batch across a later batch's arrival
    wait_half(1'b1);
    repeat (5) @(posedge clk); #1 ready = 1'b0;
    start = ngot;
    wait_half(1'b0);
    wait_half(1'b1);
    repeat (8) @(posedge clk); #1;
    chk(valid == 1'b1, "R8", "valid held while stalled", valid, 1);
    chk(chan == 1'b0 && dir == 1'b1, "R8", "stalled head (chan,dir)", {chan, dir}, 1);
    ready = 1'b1;
    wait_half(1'b0);
    repeat (8) @(posedge clk); #1;
    chk(ngot >= start + 3, "R9", "entries after stall", ngot - start, 3);
    chk(got[start][7] == 1'b0 && got[start+1][7] == 1'b1, "R7", "stalled batch order",
        {got[start][7], got[start+1][7]}, 1);
    chk(got[start+1][6] == 1'b1, "R9", "second entry direction", got[start+1][6], 1);
    chk(got[start+2][6] == 1'b1 && got[start+2][7] == 1'b0, "R9",
        "next batch skips dropped falling batch (dir,chan)",
        {got[start+2][6], got[start+2][7]}, 2);

    // half-period length
    wait_half(1'b1);
    cnt = 0;
    while (ramp_p == 1'b1 && cnt < 100) begin
      @(posedge clk); #1; cnt++;
    end
    chk(cnt == HALF, "R1", "half-period length", cnt, HALF);
    chk(ramp_n == ~ramp_p, "R1", "pins complementary", ramp_n, ~ramp_p);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule